// File: doc/BRIEF.md
# Signed Extended Divider (16-bit by 8-bit)

This block divides a signed 16-bit dividend by a signed 8-bit divisor. It returns a full 16-bit signed quotient and an 8-bit signed remainder. Because the quotient is as wide as the dividend, every result fits. The one exception is -32768 divided by -1, where the true result 32768 wraps to the 16-bit pattern 0x8000. The block works on magnitudes. It first strips the operand signs and notes which results must be negated. It then runs two chained unsigned 16÷8 passes, one for each byte of the quotient, and finally restores the signs.

A client presents both operands together with a one-cycle `start_i` pulse while the unit is idle. The unit raises `busy_o` while it iterates. It then pulses `done_o` and holds the quotient, the remainder and the zero-divide flag on its registered outputs until the next completion. A zero divisor is caught as the command is accepted: no iteration runs, and the command completes at once with the flag set.

Top module: `sdiv16x8`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `zero_div_o`, `quotient_o` and `remainder_o` are all zero.
- R2: For a nonzero divisor, `quotient_o` is the two's-complement 16-bit pattern of the true quotient rounded toward zero. The quotient is therefore negative exactly when the operand signs differ. For -32768 / -1 the pattern is 0x8000.
- R3: For a nonzero divisor, `remainder_o` equals dividend minus quotient times divisor. It is either zero or has the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R4: A divisor of -128 (0x80) and a dividend of -32768 (0x8000) give correct results under R2 and R3, for every partner operand.
- R5: A start with divisor 0 is not iterated. `done_o` pulses in the next cycle with `zero_div_o` = 1, both `quotient_o` and `remainder_o` are 0, and `busy_o` stays low.
- R6: A start with a nonzero divisor raises `busy_o` in the next cycle. `done_o` pulses 17 cycles after the accepting edge, and `busy_o` falls in that same cycle. `busy_o` and `done_o` are never high together.
- R7: `start_i` is ignored while `busy_o` is high: the operands of the running command are kept and no extra completion occurs. `done_o` lasts one cycle per accepted command.
- R8: `quotient_o`, `remainder_o` and `zero_div_o` change only in a cycle in which `done_o` is high. A start accepted in the cycle that `done_o` is high is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when `busy_o` is low |
| dividend_i | input | 16 | Signed dividend, sampled on acceptance |
| divisor_i | input | 8 | Signed divisor, sampled on acceptance |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| zero_div_o | output | 1 | Last completed command had a zero divisor |
| quotient_o | output | 16 | Signed quotient of the last completed command |
| remainder_o | output | 8 | Signed remainder of the last completed command |

## Verification
The hardest situations to reach are the magnitude extremes: a divisor of -128 and a dividend of -32768. Their magnitudes only fit because they are held unsigned. A start pulsed with fresh operands in the middle of an iteration is also hard to reach, as is a start arriving in the very cycle `done_o` is high. The stimulus sweeps all 256 divisor values against both extreme dividends, and it issues commands back to back so that every new start lands in the completion cycle of the previous one. It also injects a zero-divisor start halfway through a running division. A behavioural model built on integer division checks every output on every clock.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_FIX  = 2'd3
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_cneg.sv
// Conditional two's-complement negation, used for magnitude extraction and sign restore.
module sdiv_cneg #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         neg_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    res_o = neg_i ? (~val_i + W'(1)) : val_i;
  end
endmodule

// File: rtl/sdiv_rstep.sv
// One restoring shift-subtract step on unsigned magnitudes.
module sdiv_rstep #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic         bit_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic         qbit_o
);
  logic [W:0]   trial;
  logic [W-1:0] diff;

  always_comb begin
    trial  = {rem_i, bit_i};
    qbit_o = (trial >= {1'b0, dvs_i});
    diff   = trial[W-1:0] - dvs_i;
    rem_o  = qbit_o ? diff : trial[W-1:0];
  end
endmodule

// File: rtl/sdiv16x8.sv
module sdiv16x8
  import sdiv_pkg::*;
#(
  parameter  int DVS_W = 8,
  localparam int DVD_W = 2 * DVS_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             zero_div_o,
  output logic [DVD_W-1:0] quotient_o,
  output logic [DVS_W-1:0] remainder_o
);
  localparam int STEP_W = (DVS_W > 1) ? $clog2(DVS_W) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DVS_W - 1);

  sdiv_state_e       state_q;
  logic [STEP_W-1:0] step_q;
  logic [DVS_W-1:0]  dvs_mag_q;
  logic [DVD_W-1:0]  sh_q;
  logic [DVS_W-1:0]  rem_q;
  logic              qneg_q;
  logic              rneg_q;
  logic              busy_q;
  logic              done_q;
  logic              dz_q;
  logic [DVD_W-1:0]  quot_q;
  logic [DVS_W-1:0]  remo_q;

  // operand magnitudes
  logic             dvd_neg, dvs_neg;
  logic [DVD_W-1:0] dvd_mag;
  logic [DVS_W-1:0] dvs_mag;

  assign dvd_neg = dividend_i[DVD_W-1];
  assign dvs_neg = divisor_i[DVS_W-1];

  sdiv_cneg #(.W(DVD_W)) u_dvd_mag (.val_i(dividend_i), .neg_i(dvd_neg), .res_o(dvd_mag));
  sdiv_cneg #(.W(DVS_W)) u_dvs_mag (.val_i(divisor_i),  .neg_i(dvs_neg), .res_o(dvs_mag));

  // shared iteration datapath: quotient bits enter at the bottom of sh_q
  logic [DVS_W-1:0] rem_n;
  logic             qbit;

  sdiv_rstep #(.W(DVS_W)) u_step (
    .rem_i (rem_q),
    .bit_i (sh_q[DVD_W-1]),
    .dvs_i (dvs_mag_q),
    .rem_o (rem_n),
    .qbit_o(qbit)
  );

  // sign restore
  logic [DVD_W-1:0] quot_fix;
  logic [DVS_W-1:0] rem_fix;

  sdiv_cneg #(.W(DVD_W)) u_q_fix (.val_i(sh_q),  .neg_i(qneg_q), .res_o(quot_fix));
  sdiv_cneg #(.W(DVS_W)) u_r_fix (.val_i(rem_q), .neg_i(rneg_q), .res_o(rem_fix));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      dvs_mag_q <= '0;
      sh_q      <= '0;
      rem_q     <= '0;
      qneg_q    <= 1'b0;
      rneg_q    <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      dz_q      <= 1'b0;
      quot_q    <= '0;
      remo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (divisor_i == '0) begin
              dz_q   <= 1'b1;
              quot_q <= '0;
              remo_q <= '0;
              done_q <= 1'b1;
            end else begin
              sh_q      <= dvd_mag;
              dvs_mag_q <= dvs_mag;
              rem_q     <= '0;
              qneg_q    <= dvs_neg ^ dvd_neg;
              rneg_q    <= dvd_neg;
              step_q    <= '0;
              busy_q    <= 1'b1;
              state_q   <= ST_HI;
            end
          end
        end
        ST_HI, ST_LO: begin
          rem_q  <= rem_n;
          sh_q   <= {sh_q[DVD_W-2:0], qbit};
          step_q <= step_q + STEP_W'(1);
          if (step_q == LAST_STEP) begin
            step_q  <= '0;
            state_q <= (state_q == ST_HI) ? ST_LO : ST_FIX;
          end
        end
        ST_FIX: begin
          quot_q  <= quot_fix;
          remo_q  <= rem_fix;
          dz_q    <= 1'b0;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign zero_div_o  = dz_q;
  assign quotient_o  = quot_q;
  assign remainder_o = remo_q;

  // ---------------- assertions ----------------
  assert_busy_done_excl_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(busy_q && done_q));

  assert_busy_ends_with_done_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |=> (busy_q || done_q));

  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && start_i) |=> $stable(dvs_mag_q));

  assert_zero_div_outputs_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_q && dz_q) |-> (quot_q == '0 && remo_q == '0 && !busy_q));

  assert_rem_sign_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_q && !dz_q && remo_q != '0) |-> (remo_q[DVS_W-1] == rneg_q));

  assert_rem_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != ST_IDLE) |-> (rem_q < dvs_mag_q));

  assert_outputs_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!done_q && !$past(rst_i)) |-> ($stable(quot_q) && $stable(remo_q) && $stable(dz_q)));
endmodule

// File: tb/sdiv16x8_bench.sv
`timescale 1ns/1ps
module sdiv16x8_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] dvd = '0;
  logic [7:0]  dvs = '0;
  logic        busy, done, dz;
  logic [15:0] quot;
  logic [7:0]  rem;

  always #2.5 clk = ~clk;

  sdiv16x8 u_sdiv16x8 (
    .clk_i(clk), .rst_i(rst), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .zero_div_o(dz),
    .quotient_o(quot), .remainder_o(rem)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;
  string tag_q = "R2";
  string tag_r = "R3";

  // behavioural reference model
  bit          m_busy = 0, m_done = 0, m_dz = 0;
  logic [15:0] m_q = '0;
  logic [7:0]  m_r = '0;
  int          m_cnt = 0;
  logic [15:0] h_dvd = '0;
  logic [7:0]  h_dvs = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_q = '0; m_r = '0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        if (dvs == 8'd0) begin
          m_done = 1; m_dz = 1; m_q = '0; m_r = '0;
        end else begin
          m_busy = 1; m_cnt = 17; h_dvd = dvd; h_dvs = dvs;
        end
      end else if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          int ai, bi, qi, ri;
          ai = int'($signed(h_dvd));
          bi = int'($signed(h_dvs));
          qi = ai / bi;
          ri = ai % bi;
          m_busy = 0; m_done = 1; m_dz = 0;
          m_q = qi[15:0];
          m_r = ri[7:0];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=0x%0h expected=0x%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst && !finished) begin
      chk(busy == m_busy, "R6", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R6", 32'(done), 32'(m_done));
      chk(dz == m_dz, m_done ? "R5" : "R8", 32'(dz), 32'(m_dz));
      chk(quot == m_q, m_done ? tag_q : "R8", 32'(quot), 32'(m_q));
      chk(rem == m_r, m_done ? tag_r : "R8", 32'(rem), 32'(m_r));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // issue one command; b2b=1 drives start in the current (done) cycle
  task automatic do_op(input logic [15:0] a, input logic [7:0] b,
                       input string tq, input string tr, input bit b2b);
    if (!b2b) @(negedge clk);
    tag_q = tq; tag_r = tr;
    dvd = a; dvs = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", 32'(busy), 0);
    chk(done == 1'b0, "R1", 32'(done), 0);
    chk(dz == 1'b0, "R1", 32'(dz), 0);
    chk(quot == 16'd0, "R1", 32'(quot), 0);
    chk(rem == 8'd0, "R1", 32'(rem), 0);
    cmp_en = 1'b1;

    // R2/R3: sign combinations
    do_op(16'd100,   8'd7,    "R2", "R3", 0);
    do_op(-16'sd100, 8'd7,    "R2", "R3", 0);
    do_op(16'd100,   -8'sd7,  "R2", "R3", 0);
    do_op(-16'sd100, -8'sd7,  "R2", "R3", 0);
    do_op(16'd0,     8'd5,    "R2", "R3", 0);
    do_op(16'd6,     8'd7,    "R2", "R3", 0);
    do_op(16'd32767, 8'd1,    "R2", "R3", 0);
    // R5: zero divisor, then a normal op afterwards
    do_op(16'd1234,  8'd0,    "R5", "R5", 0);
    do_op(16'd1234,  8'd10,   "R2", "R3", 0);
    // R4: extremes
    do_op(16'h8000,  8'hFF,   "R4", "R4", 0);
    do_op(16'h8000,  8'h80,   "R4", "R4", 0);
    do_op(16'd32767, 8'h80,   "R4", "R4", 0);
    for (int b = 0; b < 256; b++) do_op(16'h8000, 8'(b), "R4", "R4", 1);
    for (int b = 0; b < 256; b++) do_op(16'h7FFF, 8'(b), "R4", "R4", 1);

    // R7: start while busy with a zero divisor must be ignored
    @(negedge clk);
    tag_q = "R7"; tag_r = "R7";
    dvd = 16'd1000; dvs = 8'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dvd = 16'd5; dvs = 8'd0; start = 1'b1;
    @(negedge clk);
    dvd = 16'd9; dvs = 8'd2;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    chk(dz == 1'b0, "R7", 32'(dz), 0);
    chk(quot == 16'd333, "R7", 32'(quot), 333);
    @(negedge clk);
    chk(done == 1'b0, "R7", 32'(done), 0);

    // R8/R2/R3: back-to-back pseudo-random commands
    for (int i = 0; i < 120; i++) begin
      logic [15:0] ra;
      logic [7:0]  rb;
      ra = 16'($urandom);
      rb = 8'($urandom);
      if (i % 17 == 5) rb = 8'd0;
      do_op(ra, rb, "R2", "R3", (i % 2) == 1);
    end
    repeat (25) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule